// File: doc/BRIEF.md
# Data Memory Access Unit for a 32-bit Integer Pipeline

This unit connects the memory stage of a five-stage 32-bit integer pipeline to one data-memory port. The port takes word-aligned addresses, a per-byte read mask or write mask, and may take any number of cycles to answer. The pipeline hands the unit a load or store: a byte address, the store data and the three-bit size/sign code from the instruction's funct3 field. The unit captures the operation and places a word-aligned request on the port in the next cycle. Store data goes into the byte lanes that the mask selects. The request is held steady until the memory raises its response.

In the response cycle the unit picks the addressed byte or halfword out of the returned word. It sign-extends or zero-extends that value as the size code asks, and presents it together with a one-cycle completion pulse. A busy output stalls the pipeline from the cycle a request is offered until the response arrives. The pipeline keeps its request inputs stable while busy is high. Only naturally aligned accesses are supported: halfwords on even addresses and words on multiples of four.

Top module: `ldst_access_unit`

## Requirements
- R1: Synchronous reset (active-low) drops any outstanding request. While reset is held and in the cycle after it, both masks, busy, the completion pulse and the load result are all zero.
- R2: A request offered while the unit is idle appears on the port in the next cycle. The port address equals the request address with its two low bits cleared.
- R3: The size code's low two bits select the mask. The mask is 4'b0001 shifted left by address bits [1:0] for 00 (byte), 4'b0011 shifted left by 2*address bit 1 for 01 (halfword), and 4'b1111 for 10 (word). A load drives it on the read mask and a store on the write mask. The other mask stays zero, so the two are never nonzero together.
- R4: Store data on the port carries the low byte in all four lanes for a byte store and the low halfword in both halves for a halfword store. A word store is unchanged.
- R5: While a request awaits its response, the port address, masks and write data do not change, even if the request inputs change. Both masks return to zero in the cycle after the response.
- R6: Busy is high in the cycle a request is offered to an idle unit and in every later cycle without a response. It is low in the response cycle and whenever the unit is idle with no request.
- R7: In the response cycle of a load, the completion pulse is high for exactly one cycle. The load result is then the returned word shifted right by eight times the byte offset (offset 0 or 2 for halfwords). It is sign-extended for size codes 000 and 001, zero-extended for 100 and 101, and taken whole for 010.
- R8: A new request offered in the cycle after a response is accepted. It reaches the port one cycle later.
- R9: On a store response the completion pulse is high and the load result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Pipeline offers a load or store |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_funct3 | input | 3 | Size and sign code |
| req_addr | input | XLEN | Byte address |
| req_wdata | input | XLEN | Store data, right-aligned |
| mem_addr | output | XLEN | Word-aligned port address |
| mem_rmask | output | XLEN/8 | Per-byte read strobe |
| mem_wmask | output | XLEN/8 | Per-byte write strobe |
| mem_wdata | output | XLEN | Lane-placed store data |
| mem_resp | input | 1 | Memory answers the held request |
| mem_rdata | input | XLEN | Word returned by memory |
| busy | output | 1 | Stall request to the pipeline |
| rsp_done | output | 1 | One-cycle completion pulse |
| load_data | output | XLEN | Extended load result |

## Verification
The bench builds the unit at its default XLEN of 32, so the port has four byte lanes and every byte and halfword offset of a word can be reached. Its vectors place each size at every legal offset, with response delays from zero to three extra cycles. Sign bits are set and clear in the returned words. A back-to-back pair of accesses and a reset during an open request cover the edges of the request lifetime.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [1:0] {
        WID_BYTE = 2'b00,
        WID_HALF = 2'b01,
        WID_WORD = 2'b10
    } width_e;

    function automatic width_e width_of(input logic [2:0] f3);
        case (f3[1:0])
            2'b00:   return WID_BYTE;
            2'b01:   return WID_HALF;
            default: return WID_WORD;
        endcase
    endfunction

endpackage

// File: rtl/ldst_lane_encode.sv
module ldst_lane_encode
    import ldst_pkg::*;
#(
    parameter  int XLEN  = 32,
    localparam int NB    = XLEN / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  width_e            width,
    input  logic [OFF_W-1:0]  offset,
    input  logic [XLEN-1:0]   store_data,
    output logic [NB-1:0]     mask,
    output logic [XLEN-1:0]   lane_data
);

    always_comb begin
        case (width)
            WID_BYTE: mask = NB'(1) << offset;
            WID_HALF: mask = NB'(3) << {offset[OFF_W-1:1], 1'b0};
            default:  mask = '1;
        endcase
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] lane_b;
        always_comb begin
            case (width)
                WID_BYTE: lane_b = store_data[7:0];
                WID_HALF: lane_b = store_data[8*(i%2) +: 8];
                default:  lane_b = store_data[8*i +: 8];
            endcase
        end
        assign lane_data[8*i +: 8] = lane_b;
    end

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
    import ldst_pkg::*;
#(
    parameter  int XLEN  = 32,
    localparam int NB    = XLEN / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  width_e            width,
    input  logic              zext,
    input  logic [OFF_W-1:0]  offset,
    input  logic [XLEN-1:0]   raw,
    output logic [XLEN-1:0]   value
);

    logic [OFF_W-1:0] eff_off;
    logic [XLEN-1:0]  shifted;

    always_comb begin
        case (width)
            WID_BYTE: eff_off = offset;
            WID_HALF: eff_off = {offset[OFF_W-1:1], 1'b0};
            default:  eff_off = '0;
        endcase
        shifted = raw >> {eff_off, 3'b000};
        case (width)
            WID_BYTE: value = zext ? {{(XLEN-8){1'b0}}, shifted[7:0]}
                                   : {{(XLEN-8){shifted[7]}}, shifted[7:0]};
            WID_HALF: value = zext ? {{(XLEN-16){1'b0}}, shifted[15:0]}
                                   : {{(XLEN-16){shifted[15]}}, shifted[15:0]};
            default:  value = shifted;
        endcase
    end

endmodule

// File: rtl/ldst_access_unit.sv
module ldst_access_unit
    import ldst_pkg::*;
#(
    parameter  int XLEN  = 32,
    localparam int NB    = XLEN / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic [2:0]       req_funct3,
    input  logic [XLEN-1:0]  req_addr,
    input  logic [XLEN-1:0]  req_wdata,
    output logic [XLEN-1:0]  mem_addr,
    output logic [NB-1:0]    mem_rmask,
    output logic [NB-1:0]    mem_wmask,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_resp,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             rsp_done,
    output logic [XLEN-1:0]  load_data
);

    typedef struct packed {
        logic             pending;
        logic             store;
        width_e           width;
        logic             zext;
        logic [OFF_W-1:0] offset;
        logic [XLEN-1:0]  addr;
        logic [NB-1:0]    mask;
        logic [XLEN-1:0]  wdata;
    } state_t;

    state_t          st_d, st_q;
    width_e          req_width;
    logic [NB-1:0]   enc_mask;
    logic [XLEN-1:0] enc_data;
    logic [XLEN-1:0] ext_value;

    assign req_width = width_of(req_funct3);

    ldst_lane_encode #(.XLEN(XLEN)) u_encode (
        .width      (req_width),
        .offset     (req_addr[OFF_W-1:0]),
        .store_data (req_wdata),
        .mask       (enc_mask),
        .lane_data  (enc_data)
    );

    ldst_load_extract #(.XLEN(XLEN)) u_extract (
        .width  (st_q.width),
        .zext   (st_q.zext),
        .offset (st_q.offset),
        .raw    (mem_rdata),
        .value  (ext_value)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.pending) begin
            if (req_valid) begin
                st_d.pending = 1'b1;
                st_d.store   = req_store;
                st_d.width   = req_width;
                st_d.zext    = req_funct3[2];
                st_d.offset  = req_addr[OFF_W-1:0];
                st_d.addr    = {req_addr[XLEN-1:OFF_W], {OFF_W{1'b0}}};
                st_d.mask    = enc_mask;
                st_d.wdata   = enc_data;
            end
        end else if (mem_resp) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = st_q.addr;
    assign mem_rmask = (st_q.pending && !st_q.store) ? st_q.mask : '0;
    assign mem_wmask = (st_q.pending &&  st_q.store) ? st_q.mask : '0;
    assign mem_wdata = st_q.wdata;
    assign busy      = (req_valid && !st_q.pending) || (st_q.pending && !mem_resp);
    assign rsp_done  = st_q.pending && mem_resp;
    assign load_data = (rsp_done && !st_q.store) ? ext_value : '0;

    logic strobe;
    assign strobe = (|mem_rmask) || (|mem_wmask);

    assert_aligned_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> mem_addr[OFF_W-1:0] == '0);

    assert_issue_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !strobe && !rsp_done) |=>
            (strobe && mem_addr[XLEN-1:OFF_W] == $past(req_addr[XLEN-1:OFF_W])));

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !((|mem_rmask) && (|mem_wmask)));

    assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && busy) |=> ($stable(mem_addr) && $stable(mem_rmask) &&
                              $stable(mem_wmask) && $stable(mem_wdata)));

    assert_drop_after_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !strobe);

    assert_busy_on_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !strobe) |-> busy);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/ldst_access_unit_bench.sv
`timescale 1ns/1ps
module ldst_access_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store;
    logic [2:0]  req_funct3;
    logic [31:0] req_addr, req_wdata;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
    logic [3:0]  mem_rmask, mem_wmask;
    logic        mem_resp, busy, rsp_done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ldst_access_unit u_ldst_access_unit (
        .clk, .rst_n, .req_valid, .req_store, .req_funct3, .req_addr, .req_wdata,
        .mem_addr, .mem_rmask, .mem_wmask, .mem_wdata, .mem_resp, .mem_rdata,
        .busy, .rsp_done, .load_data
    );

    typedef struct packed {
        logic        st;
        logic [2:0]  f3;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] rword;
        logic [3:0]  mask;
        logic [31:0] exp;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'b000, 32'h1000_0003, 32'h0,         32'h8011_2233, 4'b1000, 32'hFFFF_FF80, 4'd1},
        '{1'b0, 3'b100, 32'h1000_0003, 32'h0,         32'h8011_2233, 4'b1000, 32'h0000_0080, 4'd2},
        '{1'b0, 3'b000, 32'h1000_0101, 32'h0,         32'h1122_7F44, 4'b0010, 32'h0000_007F, 4'd0},
        '{1'b0, 3'b001, 32'h1000_0202, 32'h0,         32'h8001_1234, 4'b1100, 32'hFFFF_8001, 4'd3},
        '{1'b0, 3'b101, 32'h1000_0202, 32'h0,         32'h8001_1234, 4'b1100, 32'h0000_8001, 4'd1},
        '{1'b0, 3'b001, 32'h1000_0300, 32'h0,         32'hABCD_7FFE, 4'b0011, 32'h0000_7FFE, 4'd0},
        '{1'b0, 3'b010, 32'h1ECE_B004, 32'h0,         32'hDEAD_BEEF, 4'b1111, 32'hDEAD_BEEF, 4'd2},
        '{1'b0, 3'b100, 32'h1000_0400, 32'h0,         32'h1234_56FE, 4'b0001, 32'h0000_00FE, 4'd0},
        '{1'b1, 3'b000, 32'h2000_0002, 32'h1234_5678, 32'hFFFF_FFFF, 4'b0100, 32'h7878_7878, 4'd1},
        '{1'b1, 3'b000, 32'h2000_0013, 32'hAABB_CCDD, 32'hFFFF_FFFF, 4'b1000, 32'hDDDD_DDDD, 4'd0},
        '{1'b1, 3'b001, 32'h2000_0022, 32'h0000_BEEF, 32'hFFFF_FFFF, 4'b1100, 32'hBEEF_BEEF, 4'd2},
        '{1'b1, 3'b001, 32'h2000_0030, 32'hFFFF_1234, 32'hFFFF_FFFF, 4'b0011, 32'h1234_1234, 4'd0},
        '{1'b1, 3'b010, 32'h2000_0048, 32'hCAFE_F00D, 32'hFFFF_FFFF, 4'b1111, 32'hCAFE_F00D, 4'd1}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_access(input vec_t v);
        logic [31:0] held_addr, held_wdata;
        logic [3:0]  held_r, held_w;
        @(negedge clk);
        req_valid = 1'b1; req_store = v.st; req_funct3 = v.f3;
        req_addr = v.addr; req_wdata = v.wdata; mem_resp = 1'b0;
        #1;
        chk({31'b0, busy}, 32'd1, "R6 busy in offer cycle");
        chk({28'b0, mem_rmask | mem_wmask}, 32'd0, "R2 no strobe before edge");
        @(negedge clk);
        chk(mem_addr, {v.addr[31:2], 2'b00}, "R2 aligned port address");
        chk({28'b0, v.st ? mem_wmask : mem_rmask}, {28'b0, v.mask}, "R3 lane mask");
        chk({28'b0, v.st ? mem_rmask : mem_wmask}, 32'd0, "R3 opposite mask idle");
        if (v.st) chk(mem_wdata, v.exp, "R4 lane-placed store data");
        held_addr = mem_addr; held_wdata = mem_wdata; held_r = mem_rmask; held_w = mem_wmask;
        req_addr = ~v.addr; req_wdata = ~v.wdata; req_funct3 = 3'b010; req_store = ~v.st;
        for (int k = 0; k < int'(v.lat); k++) begin
            chk({31'b0, busy}, 32'd1, "R6 busy while waiting");
            chk({31'b0, rsp_done}, 32'd0, "R7 no early completion");
            @(negedge clk);
            chk(mem_addr, held_addr, "R5 address held");
            chk({24'b0, held_r, held_w}, {24'b0, mem_rmask, mem_wmask}, "R5 masks held");
            chk(mem_wdata, held_wdata, "R5 write data held");
        end
        mem_resp = 1'b1; mem_rdata = v.rword;
        #1;
        chk({31'b0, busy}, 32'd0, "R6 busy low on response");
        chk({31'b0, rsp_done}, 32'd1, "R7 completion pulse");
        if (v.st) chk(load_data, 32'd0, "R9 store gives zero result");
        else      chk(load_data, v.exp, "R7 extended load result");
        @(negedge clk);
        mem_resp = 1'b0; req_valid = 1'b0;
        #1;
        chk({28'b0, mem_rmask | mem_wmask}, 32'd0, "R5 strobes dropped after response");
        chk({31'b0, rsp_done}, 32'd0, "R7 pulse lasts one cycle");
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_funct3 = 3'b0;
        req_addr = '0; req_wdata = '0; mem_resp = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk({24'b0, mem_rmask, mem_wmask}, 32'd0, "R1 masks zero in reset");
        chk({30'b0, busy, rsp_done}, 32'd0, "R1 busy and done low in reset");
        chk(load_data, 32'd0, "R1 load result zero in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({31'b0, busy}, 32'd0, "R6 idle without request");

        for (int i = 0; i < NV; i++) run_access(VECS[i]);

        // R8: back-to-back, load then store offered in the cycle after the response
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_funct3 = 3'b010; req_addr = 32'h0000_0020;
        @(negedge clk);
        mem_resp = 1'b1; mem_rdata = 32'h0BAD_F00D;
        #1 chk(load_data, 32'h0BAD_F00D, "R8 first access result");
        @(negedge clk);
        mem_resp = 1'b0; req_store = 1'b1; req_funct3 = 3'b000;
        req_addr = 32'h0000_0041; req_wdata = 32'h0000_005A;
        #1;
        chk({31'b0, busy}, 32'd1, "R8 next request accepted");
        chk({28'b0, mem_rmask | mem_wmask}, 32'd0, "R8 no strobe in accept cycle");
        @(negedge clk);
        chk({28'b0, mem_wmask}, 32'h2, "R8 second access mask");
        chk(mem_addr, 32'h0000_0040, "R8 second access address");
        chk(mem_wdata, 32'h5A5A_5A5A, "R8 second access data");
        mem_resp = 1'b1;
        @(negedge clk);
        mem_resp = 1'b0; req_valid = 1'b0;

        // R1: reset while a request is open
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_funct3 = 3'b001; req_addr = 32'h0000_0082;
        @(negedge clk);
        chk({28'b0, mem_rmask}, 32'hC, "R1 request open before reset");
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk({24'b0, mem_rmask, mem_wmask}, 32'd0, "R1 reset drops request");
        chk({30'b0, busy, rsp_done}, 32'd0, "R1 busy and done low after reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({24'b0, mem_rmask, mem_wmask}, 32'd0, "R1 nothing left after reset");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog R1-all actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule